// File: doc/BRIEF.md
# Self-Restarting Region Read Engine

This block is a read-only memory master for a 64-bit AXI4 bus. Software first stores a payload in a fixed address window. It then sets a start address, an exclusive end address and a burst size in beats, and raises an enable. From then on the engine fetches the window burst by burst and pushes every returned beat into the write port of a downstream FIFO. That FIFO handles width conversion and clock crossing for the consumer.

Software does not re-arm each burst. Instead, the engine launches the next burst whenever the FIFO reports that it holds nothing. It walks up through the window and returns to the start address when the next burst would not fit. The effect is a continuous, looping playback of the stored data. Only one burst is in flight at any time. A bad read response is remembered, but it does not stop the engine.

Top module: `dma_burst_reader`

## Requirements
- R1: Each read request carries m_arlen = burst_len-1, m_arsize = log2 of the bus width in bytes (3 for a 64-bit bus), and m_arburst = 2'b01 (incrementing).
- R2: Once raised, m_arvalid stays high with m_araddr and m_arlen unchanged until a cycle with m_arready high. It is low in the cycle after that handshake.
- R3: A new request is raised only after a cycle in which fifo_wr_count was zero and no FIFO write pulse was pending. While the count stays non-zero, no request is issued, however long that lasts.
- R4: The first burst after enabling starts at start_addr. Each later burst starts burst_len x 8 bytes above the previous one.
- R5: If the next start address plus one burst length in bytes exceeds end_addr (end_addr is exclusive), the next burst starts at start_addr instead.
- R6: At most one burst is outstanding. m_rready is high exactly while a burst's data is awaited, and m_arvalid is never high while m_rready is high.
- R7: Every beat accepted on the read data channel produces exactly one fifo_wr_en pulse in the following cycle, with fifo_wr_data equal to that beat's data.
- R8: A beat accepted with m_rresp not equal to 2'b00 sets rd_err in the next cycle. rd_err stays set until reset, and bursts keep being issued.
- R9: If run_en drops mid-burst, that burst still completes and all of its beats are written. No further request follows. When run_en is raised again, fetching restarts at start_addr.
- R10: During and just after reset, m_arvalid, m_rready, fifo_wr_en and rd_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Engine enable, sampled between bursts |
| start_addr | input | ADDR_W | First byte address of the window |
| end_addr | input | ADDR_W | Exclusive upper byte address of the window |
| burst_len | input | LEN_W+1 | Beats per burst, 1 to 2^LEN_W |
| m_araddr | output | ADDR_W | Read request address |
| m_arlen | output | LEN_W | Read request length minus one |
| m_arsize | output | 3 | Read request beat size code |
| m_arburst | output | 2 | Read request burst type |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_rdata | input | DATA_W | Read beat data |
| m_rresp | input | 2 | Read beat response |
| m_rlast | input | 1 | Final beat of burst |
| m_rvalid | input | 1 | Read beat valid |
| m_rready | output | 1 | Read beat accept |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | DATA_W | FIFO write data |
| fifo_wr_count | input | CNT_W | FIFO write-side fill count |
| rd_err | output | 1 | Sticky read error |

## Verification
The hardest situation to create from the ports is a stall caused by a FIFO that does not drain. The R3 gate only shows its effect when the fill count stays non-zero long after a burst has finished. The bench therefore models the FIFO with a drain switch and turns it off. It then confirms that a long wait produces no new request, and that fetching resumes once draining is switched back on. A second case that is hard to reach is dropping the enable while beats are still arriving. The bench lowers run_en at the moment a beat is presented, then checks that the burst ends on a whole-burst boundary and that the restart begins at the window base.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } rd_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

endpackage

// File: rtl/dma_rd_addr_gen.sv
module dma_rd_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 8,
    parameter int SIZE_LG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [LEN_W:0]    burst_len,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int SUM_W = ADDR_W + 2;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ag_regs_t;

    ag_regs_t ag_d, ag_q;

    logic [SUM_W-1:0] step_bytes;
    logic [SUM_W-1:0] cand_start;
    logic [SUM_W-1:0] cand_stop;
    logic             cand_fits;

    always_comb begin
        step_bytes = SUM_W'(burst_len) << SIZE_LG;
        cand_start = {2'b00, ag_q.ptr} + step_bytes;
        cand_stop  = cand_start + step_bytes;
        cand_fits  = (cand_stop <= {2'b00, end_addr});

        ag_d = ag_q;
        if (load_base) begin
            ag_d.ptr = base_addr;
        end else if (advance) begin
            ag_d.ptr = cand_fits ? cand_start[ADDR_W-1:0] : base_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign cur_addr = ag_q.ptr;

endmodule

// File: rtl/dma_rd_ctrl.sv
module dma_rd_ctrl
    import dma_rd_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [LEN_W:0]   burst_len,
    input  logic             fifo_empty,
    input  logic             wr_busy,
    input  logic             arready,
    input  logic             rvalid,
    input  logic             rlast,
    output logic             arvalid,
    output logic [LEN_W-1:0] arlen,
    output logic             rready,
    output logic             load_base,
    output logic             advance
);
    typedef struct packed {
        rd_state_e        state;
        logic             armed;
        logic [LEN_W-1:0] len_m1;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        load_base = 1'b0;
        advance   = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (!run_en) begin
                    ctl_d.armed = 1'b0;
                end else if (!ctl_q.armed) begin
                    load_base   = 1'b1;
                    ctl_d.armed = 1'b1;
                end else if (fifo_empty && !wr_busy) begin
                    ctl_d.state  = ST_ADDR;
                    ctl_d.len_m1 = LEN_W'(burst_len - 1'b1);
                end
            end
            ST_ADDR: begin
                if (arready) begin
                    ctl_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (rvalid && rlast) begin
                    ctl_d.state = ST_IDLE;
                    advance     = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.armed  <= 1'b0;
            ctl_q.len_m1 <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign arvalid = (ctl_q.state == ST_ADDR);
    assign rready  = (ctl_q.state == ST_DATA);
    assign arlen   = ctl_q.len_m1;

endmodule

// File: rtl/dma_rd_beat_sink.sv
module dma_rd_beat_sink
    import dma_rd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_ok,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [1:0]        beat_resp,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_flag
);
    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
        logic              err;
    } snk_regs_t;

    snk_regs_t snk_d, snk_q;

    always_comb begin
        snk_d    = snk_q;
        snk_d.wr = beat_ok;
        if (beat_ok) begin
            snk_d.data = beat_data;
            if (beat_resp != RESP_OKAY) begin
                snk_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snk_q <= '0;
        end else begin
            snk_q <= snk_d;
        end
    end

    assign wr_en    = snk_q.wr;
    assign wr_data  = snk_q.data;
    assign err_flag = snk_q.err;

endmodule

// File: rtl/dma_burst_reader.sv
module dma_burst_reader
    import dma_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [LEN_W:0]    burst_len,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [LEN_W-1:0]  m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    input  logic              m_rvalid,
    output logic              m_rready,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    input  logic [CNT_W-1:0]  fifo_wr_count,
    output logic              rd_err
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int SIZE_LG    = $clog2(BEAT_BYTES);

    logic load_base;
    logic advance;
    logic fifo_empty;
    logic beat_ok;

    assign fifo_empty = (fifo_wr_count == '0);
    assign beat_ok    = m_rvalid && m_rready;
    assign m_arsize   = 3'(SIZE_LG);
    assign m_arburst  = BURST_INCR;

    dma_rd_ctrl #(
        .LEN_W(LEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .burst_len (burst_len),
        .fifo_empty(fifo_empty),
        .wr_busy   (fifo_wr_en),
        .arready   (m_arready),
        .rvalid    (m_rvalid),
        .rlast     (m_rlast),
        .arvalid   (m_arvalid),
        .arlen     (m_arlen),
        .rready    (m_rready),
        .load_base (load_base),
        .advance   (advance)
    );

    dma_rd_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SIZE_LG(SIZE_LG)
    ) agen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_base(load_base),
        .advance  (advance),
        .base_addr(start_addr),
        .end_addr (end_addr),
        .burst_len(burst_len),
        .cur_addr (m_araddr)
    );

    dma_rd_beat_sink #(
        .DATA_W(DATA_W)
    ) sink_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_ok  (beat_ok),
        .beat_data(m_rdata),
        .beat_resp(m_rresp),
        .wr_en    (fifo_wr_en),
        .wr_data  (fifo_wr_data),
        .err_flag (rd_err)
    );

endmodule

// File: rtl/dma_rd_checker.sv
module dma_rd_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [ADDR_W-1:0] m_araddr,
    input logic [LEN_W-1:0]  m_arlen,
    input logic [2:0]        m_arsize,
    input logic [1:0]        m_arburst,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [DATA_W-1:0] m_rdata,
    input logic [1:0]        m_rresp,
    input logic              m_rvalid,
    input logic              m_rready,
    input logic              fifo_wr_en,
    input logic [DATA_W-1:0] fifo_wr_data,
    input logic [CNT_W-1:0]  fifo_wr_count,
    input logic              rd_err
);
    localparam logic [2:0] EXP_SIZE = 3'($clog2(DATA_W / 8));

    assert_req_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_arburst == 2'b01) && (m_arsize == EXP_SIZE));

    assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

    assert_ar_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_arready) |=> !m_arvalid);

    assert_empty_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_arvalid) |-> ($past(fifo_wr_count) == '0) && !$past(fifo_wr_en));

    assert_single_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_rready |-> !m_arvalid);

    assert_beat_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && m_rready) |=> fifo_wr_en && (fifo_wr_data == $past(m_rdata)));

    assert_no_spurious_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rvalid && m_rready) |=> !fifo_wr_en);

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && m_rready && (m_rresp != 2'b00)) |=> rd_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err);

    assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !m_arvalid && !m_rready) |=> !m_arvalid);

endmodule

bind dma_burst_reader dma_rd_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .m_araddr     (m_araddr),
    .m_arlen      (m_arlen),
    .m_arsize     (m_arsize),
    .m_arburst    (m_arburst),
    .m_arvalid    (m_arvalid),
    .m_arready    (m_arready),
    .m_rdata      (m_rdata),
    .m_rresp      (m_rresp),
    .m_rvalid     (m_rvalid),
    .m_rready     (m_rready),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .fifo_wr_count(fifo_wr_count),
    .rd_err       (rd_err)
);

// File: tb/dma_burst_reader_tb_top.sv
`timescale 1ns/1ps
module dma_burst_reader_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = 10;
    localparam int NVEC   = 6;

    localparam logic [8:0]  V_LEN   [NVEC] = '{9'd4, 9'd4, 9'd1, 9'd16, 9'd2, 9'd256};
    localparam logic [31:0] V_BASE  [NVEC] = '{32'h1000, 32'h1000, 32'h2000, 32'h0, 32'h3000, 32'h10000};
    localparam logic [31:0] V_LIMIT [NVEC] = '{32'h1080, 32'h1070, 32'h2020, 32'h400, 32'h3018, 32'h11000};
    localparam int          V_LAP   [NVEC] = '{4, 3, 4, 8, 1, 2};
    localparam int          V_ARDLY [NVEC] = '{0, 2, 1, 0, 3, 0};
    localparam int          V_GAP   [NVEC] = '{0, 1, 0, 2, 0, 0};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [ADDR_W-1:0] end_addr = '0;
    logic [LEN_W:0]    burst_len = 9'd4;
    logic [ADDR_W-1:0] m_araddr;
    logic [LEN_W-1:0]  m_arlen;
    logic [2:0]        m_arsize;
    logic [1:0]        m_arburst;
    logic              m_arvalid;
    logic              m_arready = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0;
    logic [1:0]        m_rresp = 2'b00;
    logic              m_rlast = 1'b0;
    logic              m_rvalid = 1'b0;
    logic              m_rready;
    logic              fifo_wr_en;
    logic [DATA_W-1:0] fifo_wr_data;
    logic [CNT_W-1:0]  fifo_wr_count;
    logic              rd_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int ar_dly = 0;
    int beat_gap = 0;
    bit inject_err = 1'b0;
    bit slave_busy = 1'b0;
    int ar_cnt = 0;
    logic [31:0] ar_log [0:1023];
    logic [7:0]  len_log [0:1023];

    bit drain = 1'b1;
    int fcount = 0;
    int wr_b = 0;
    int wr_beat = 0;
    int wr_total = 0;

    assign fifo_wr_count = CNT_W'(fcount);

    dma_burst_reader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .start_addr(start_addr), .end_addr(end_addr), .burst_len(burst_len),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_wr_count(fifo_wr_count), .rd_err(rd_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_word(input logic [31:0] a);
        return {a, ~a};
    endfunction

    // memory-side responder
    initial begin
        logic [31:0] a0;
        logic [7:0]  l0;
        forever begin
            @(negedge clk);
            if (rst_n && m_arvalid) begin
                slave_busy = 1'b1;
                a0 = m_araddr;
                repeat (ar_dly) @(negedge clk);
                chk(m_arvalid && m_araddr == a0, "R2", "request held", {32'h0, m_araddr}, {32'h0, a0});
                chk(m_arsize == 3'd3 && m_arburst == 2'b01, "R1", "size/burst",
                    {59'h0, m_arsize, m_arburst}, {59'h0, 3'd3, 2'b01});
                l0 = m_arlen;
                if (ar_cnt < 1024) begin
                    ar_log[ar_cnt]  = a0;
                    len_log[ar_cnt] = l0;
                end
                ar_cnt++;
                m_arready = 1'b1;
                @(negedge clk);
                m_arready = 1'b0;
                chk(!m_arvalid, "R2", "request dropped after handshake", {63'h0, m_arvalid}, 64'h0);
                for (int i = 0; i <= int'(l0); i++) begin
                    repeat (beat_gap) @(negedge clk);
                    m_rvalid = 1'b1;
                    m_rdata  = beat_word(a0 + 32'(i * 8));
                    m_rlast  = (i == int'(l0));
                    m_rresp  = 2'b00;
                    if (inject_err && i == 0) begin
                        m_rresp = 2'b10;
                        inject_err = 1'b0;
                    end
                    chk(m_rready && !m_arvalid, "R6", "ready during burst, no request",
                        {62'h0, m_rready, m_arvalid}, 64'h2);
                    @(negedge clk);
                    m_rvalid = 1'b0;
                    m_rlast  = 1'b0;
                    m_rresp  = 2'b00;
                end
                slave_busy = 1'b0;
            end
        end
    end

    // FIFO model and write monitor
    initial begin
        logic [31:0] ea;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                fcount = 0;
            end else begin
                if (m_arvalid && !m_arready && slave_busy == 1'b0) begin
                    chk(fcount == 0, "R3", "request raised with non-empty FIFO", 64'(fcount), 64'h0);
                end
                if (fifo_wr_en) begin
                    ea = ar_log[wr_b] + 32'(wr_beat * 8);
                    chk(fifo_wr_data == beat_word(ea), "R7", "fifo data", fifo_wr_data, beat_word(ea));
                    fcount++;
                    wr_total++;
                    if (wr_beat >= int'(len_log[wr_b])) begin
                        wr_beat = 0;
                        wr_b++;
                    end else begin
                        wr_beat++;
                    end
                end
                if (drain && fcount > 0) fcount--;
            end
        end
    end

    task automatic wait_bursts(input int target, input string req);
        int n = 0;
        while (ar_cnt < target && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(ar_cnt >= target, req, "burst count reached", 64'(ar_cnt), 64'(target));
    endtask

    task automatic wait_quiet();
        int q = 0;
        int n = 0;
        while (q < 4 && n < 30000) begin
            @(negedge clk);
            n++;
            if (!slave_busy && !m_arvalid && !m_rready && !fifo_wr_en) q++;
            else q = 0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int b0;
        int w0;
        int sum_len;
        int mism;
        int bstop;
        logic [31:0] step;
        logic [31:0] expa;

        repeat (5) @(negedge clk);
        chk(!m_arvalid && !m_rready, "R10", "handshake outputs in reset", {62'h0, m_arvalid, m_rready}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!m_arvalid, "R10", "arvalid after reset", {63'h0, m_arvalid}, 64'h0);
        chk(!m_rready, "R10", "rready after reset", {63'h0, m_rready}, 64'h0);
        chk(!fifo_wr_en && !rd_err, "R10", "wr_en/err after reset", {62'h0, fifo_wr_en, rd_err}, 64'h0);

        // table walk: R1 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            run_en = 1'b0;
            wait_quiet();
            start_addr = V_BASE[v];
            end_addr   = V_LIMIT[v];
            burst_len  = V_LEN[v];
            ar_dly     = V_ARDLY[v];
            beat_gap   = V_GAP[v];
            drain      = 1'b1;
            b0 = ar_cnt;
            w0 = wr_total;
            @(negedge clk);
            run_en = 1'b1;
            wait_bursts(b0 + 2 * V_LAP[v] + 1, "R4");
            run_en = 1'b0;
            wait_quiet();
            step = 32'(V_LEN[v]) * 32'd8;
            mism = 0;
            sum_len = 0;
            for (int k = b0; k < ar_cnt; k++) begin
                expa = V_BASE[v] + 32'((k - b0) % V_LAP[v]) * step;
                if (ar_log[k] != expa) mism++;
                if (len_log[k] != 8'(V_LEN[v] - 9'd1)) mism++;
                sum_len += int'(len_log[k]) + 1;
            end
            chk(mism == 0, "R5", $sformatf("address/len sequence with wrap, vector %0d", v),
                64'(mism), 64'h0);
            chk(wr_total - w0 == sum_len, "R7", "one write per beat", 64'(wr_total - w0), 64'(sum_len));
        end

        // R3: FIFO not draining blocks the next burst
        wait_quiet();
        start_addr = 32'h1000;
        end_addr   = 32'h1080;
        burst_len  = 9'd4;
        ar_dly     = 0;
        beat_gap   = 0;
        drain      = 1'b0;
        b0 = ar_cnt;
        @(negedge clk);
        run_en = 1'b1;
        wait_bursts(b0 + 1, "R3");
        wait_quiet();
        repeat (40) @(negedge clk);
        chk(ar_cnt == b0 + 1, "R3", "no request while FIFO holds data", 64'(ar_cnt), 64'(b0 + 1));
        chk(fcount == 4, "R3", "FIFO fill after one burst", 64'(fcount), 64'd4);
        drain = 1'b1;
        wait_bursts(b0 + 2, "R3");
        chk(ar_log[b0 + 1] == 32'h1020, "R4", "second burst address", {32'h0, ar_log[b0 + 1]}, 64'h1020);

        // R9: stop mid-burst, then restart from the base
        beat_gap = 1;
        while (!m_rvalid) @(negedge clk);
        run_en = 1'b0;
        wait_quiet();
        bstop = ar_cnt;
        repeat (40) @(negedge clk);
        chk(ar_cnt == bstop, "R9", "no request after stop", 64'(ar_cnt), 64'(bstop));
        chk(wr_b == ar_cnt && wr_beat == 0, "R9", "stopped burst fully written", 64'(wr_b), 64'(ar_cnt));
        run_en = 1'b1;
        wait_bursts(bstop + 1, "R9");
        chk(ar_log[bstop] == 32'h1000, "R9", "restart at start address", {32'h0, ar_log[bstop]}, 64'h1000);

        // R8: error response is sticky and the engine keeps going
        chk(!rd_err, "R8", "error clear before injection", {63'h0, rd_err}, 64'h0);
        inject_err = 1'b1;
        b0 = ar_cnt;
        wait_bursts(b0 + 3, "R8");
        chk(rd_err, "R8", "error flag set", {63'h0, rd_err}, 64'h1);
        run_en = 1'b0;
        wait_quiet();
        repeat (10) @(negedge clk);
        chk(rd_err, "R8", "error flag sticky", {63'h0, rd_err}, 64'h1);

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_err && !m_arvalid, "R10", "reset clears error", {62'h0, rd_err, m_arvalid}, 64'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule